// File: doc/BRIEF.md
# Protected Erase-Block Select Register

This block is an 8-bit memory-mapped register that names the single flash block allowed to be erased next. A CPU writes and reads it through a plain strobe port. Bit n of the register stands for flash block n, for n from 0 to 7; a 1 selects the block and a 0 leaves it erase-protected. An erase sequencer outside this block reads the `erase_sel` vector and works on the one block that is flagged.

The register is protected. Any of four conditions forces it to zero and holds it there:

- system reset;
- hardware or software standby;
- a low flash-write-enable pin;
- a clear software-write-enable bit from the companion flash control register.

Writes are accepted only in operating modes 5 and 7. In every other mode the register is read-only and reads as zero. Blocks are erased one at a time. A write that sets more than one bit is therefore refused and raises a sticky error flag.

Top module: `erase_sel_reg`

## Requirements
- R1: While `rst_n` is low, the stored selection and `multi_err` are 0, and `erase_sel` and `rd_data` read 0x00.
- R2: At each clock edge where `hw_stby` or `sw_stby` is 1, the stored selection and `multi_err` clear to 0. They stay 0 for as long as the standby input is held.
- R3: At each clock edge where `fwe_pin` is 0, the stored selection clears to 0. A write presented in that cycle has no effect.
- R4: At each clock edge where `swe_bit` is 0, the stored selection clears to 0, even with `fwe_pin` high. A write presented in that cycle has no effect, so no bit can be set before `swe_bit` is 1.
- R5: When `op_mode` is not 5 and not 7, a write leaves the selection and `multi_err` unchanged, and a read returns 0x00.
- R6: In mode 5 or 7 with no clear condition, a write whose data has zero or one bit set is stored at the next clock edge. `erase_sel` bit n is then 1 exactly for the written bit n.
- R7: In mode 5 or 7 with no clear condition, a write whose data has two or more bits set leaves the selection unchanged. It sets `multi_err` at the next edge, and the flag then stays set.
- R8: `multi_err` clears at the edge after a cycle with `err_ack` high, unless a rejected write occurs in that same cycle. It also clears on any clear condition of R2 to R4.
- R9: `rd_data` holds the stored selection as it stood before the edge, in the cycle after `rd_stb`. It holds 0x00 in the cycle after a cycle with no read strobe.
- R10: `erase_sel` is the stored selection ANDed with `fwe_pin` and `swe_bit`, without a register. It drops to 0x00 in the same cycle that either enable falls.
- R11: When a clear condition and an acceptable write occur in the same cycle, the clear wins and the selection is 0x00 after the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| hw_stby | input | 1 | Hardware standby active |
| sw_stby | input | 1 | Software standby active |
| op_mode | input | 3 | Operating mode number; 5 and 7 allow writes |
| fwe_pin | input | 1 | Flash-write-enable pin level |
| swe_bit | input | 1 | Software-write-enable bit of the flash control register |
| wr_stb | input | 1 | Register write strobe, one cycle |
| wr_data | input | 8 | Write data, bit n selects block n |
| rd_stb | input | 1 | Register read strobe, one cycle |
| err_ack | input | 1 | Strobe for the error-acknowledge bit, write of 1 |
| rd_data | output | 8 | Read data, valid the cycle after `rd_stb` |
| erase_sel | output | 8 | Per-block erase select to the sequencer |
| multi_err | output | 1 | Sticky flag: a multi-bit write was refused |

## Verification
A wrong stored selection shows on `erase_sel` in the first cycle after the faulty edge while both enables are high. It also shows on `rd_data` one cycle after the next read strobe, so a missed clear or a multi-bit value is seen within two cycles. The register is hidden by the gating whenever an enable is low. For that reason, a clear that failed during protection is exposed only after the enables return high. The bench checks that case by raising them again and reading. An error flag that fails to set or to clear shows directly on `multi_err` at the edge after the causing strobe.

// File: rtl/esr_pkg.sv
package esr_pkg;
  localparam int unsigned MODE_WR_A = 5;
  localparam int unsigned MODE_WR_B = 7;

  typedef enum logic [1:0] {
    V_IDLE    = 2'd0,
    V_ACCEPT  = 2'd1,
    V_REJECT  = 2'd2,
    V_BLOCKED = 2'd3
  } wr_verdict_t;
endpackage

// File: rtl/esr_guard.sv
module esr_guard
  import esr_pkg::*;
#(
  parameter int unsigned NBLK   = 8,
  parameter int unsigned MODE_W = 3
) (
  input  logic              hw_stby,
  input  logic              sw_stby,
  input  logic              fwe_pin,
  input  logic              swe_bit,
  input  logic [MODE_W-1:0] op_mode,
  input  logic              wr_stb,
  input  logic [NBLK-1:0]   wr_data,
  output logic              force_clr,
  output logic              mode_rw,
  output logic              wr_accept,
  output logic              wr_reject
);
  function automatic int pop_count(input logic [NBLK-1:0] v);
    int n;
    n = 0;
    for (int i = 0; i < int'(NBLK); i++) n += int'(v[i]);
    return n;
  endfunction

  function automatic logic mode_writable(input logic [MODE_W-1:0] m);
    return (m == MODE_W'(MODE_WR_A)) || (m == MODE_W'(MODE_WR_B));
  endfunction

  wr_verdict_t verdict;

  always_comb begin
    force_clr = hw_stby | sw_stby | ~fwe_pin | ~swe_bit;
    mode_rw   = mode_writable(op_mode);
    if (!wr_stb)                    verdict = V_IDLE;
    else if (force_clr || !mode_rw) verdict = V_BLOCKED;
    else if (pop_count(wr_data) > 1) verdict = V_REJECT;
    else                             verdict = V_ACCEPT;
    wr_accept = (verdict == V_ACCEPT);
    wr_reject = (verdict == V_REJECT);
  end
endmodule

// File: rtl/esr_store.sv
module esr_store #(
  parameter int unsigned NBLK = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            force_clr,
  input  logic            wr_accept,
  input  logic            wr_reject,
  input  logic            err_ack,
  input  logic [NBLK-1:0] wr_data,
  output logic [NBLK-1:0] sel_q,
  output logic            err_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
      err_q <= 1'b0;
    end else if (force_clr) begin
      sel_q <= '0;
      err_q <= 1'b0;
    end else begin
      if (wr_accept) sel_q <= wr_data;
      if (wr_reject)    err_q <= 1'b1;
      else if (err_ack) err_q <= 1'b0;
    end
  end

  a_r6_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    wr_accept && !force_clr |=> sel_q == $past(wr_data));
  a_r7_reject_holds: assert property (@(posedge clk) disable iff (!rst_n)
    wr_reject && !force_clr |=> $stable(sel_q) && err_q);
  a_r2_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    force_clr |=> sel_q == '0 && !err_q);
  a_r7_single_sel: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel_q));
endmodule

// File: rtl/esr_readback.sv
module esr_readback #(
  parameter int unsigned NBLK = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rd_stb,
  input  logic            mode_rw,
  input  logic [NBLK-1:0] sel_q,
  output logic [NBLK-1:0] rd_data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 rd_data <= '0;
    else if (rd_stb && mode_rw) rd_data <= sel_q;
    else                        rd_data <= '0;
  end

  a_r9_read_value: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb && mode_rw |=> rd_data == $past(sel_q));
  a_r5_ro_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_stb && mode_rw) |=> rd_data == '0);
endmodule

// File: rtl/erase_sel_reg.sv
module erase_sel_reg #(
  parameter int unsigned NBLK   = 8,
  parameter int unsigned MODE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hw_stby,
  input  logic              sw_stby,
  input  logic [MODE_W-1:0] op_mode,
  input  logic              fwe_pin,
  input  logic              swe_bit,
  input  logic              wr_stb,
  input  logic [NBLK-1:0]   wr_data,
  input  logic              rd_stb,
  input  logic              err_ack,
  output logic [NBLK-1:0]   rd_data,
  output logic [NBLK-1:0]   erase_sel,
  output logic              multi_err
);
  logic            force_clr;
  logic            mode_rw;
  logic            wr_accept;
  logic            wr_reject;
  logic [NBLK-1:0] sel_q;

  esr_guard #(.NBLK(NBLK), .MODE_W(MODE_W)) u_guard (
    .hw_stby(hw_stby), .sw_stby(sw_stby), .fwe_pin(fwe_pin),
    .swe_bit(swe_bit), .op_mode(op_mode), .wr_stb(wr_stb),
    .wr_data(wr_data), .force_clr(force_clr), .mode_rw(mode_rw),
    .wr_accept(wr_accept), .wr_reject(wr_reject)
  );

  esr_store #(.NBLK(NBLK)) u_store (
    .clk(clk), .rst_n(rst_n), .force_clr(force_clr),
    .wr_accept(wr_accept), .wr_reject(wr_reject), .err_ack(err_ack),
    .wr_data(wr_data), .sel_q(sel_q), .err_q(multi_err)
  );

  esr_readback #(.NBLK(NBLK)) u_read (
    .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .mode_rw(mode_rw),
    .sel_q(sel_q), .rd_data(rd_data)
  );

  assign erase_sel = sel_q & {NBLK{fwe_pin & swe_bit}};

  // R10: the sequencer never sees more than one block.
  a_r10_onehot_out: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(erase_sel));
  // R3 and R4: the cycle after protection, the output is still zero.
  a_r3_prot_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !fwe_pin || !swe_bit |=> sel_q == '0);
endmodule

// File: tb/erase_sel_reg_test.sv
module erase_sel_reg_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 0;
  logic       rst_n = 0;
  logic       hw_stby = 0, sw_stby = 0;
  logic [2:0] op_mode = 3'd5;
  logic       fwe_pin = 1, swe_bit = 1;
  logic       wr_stb = 0, rd_stb = 0, err_ack = 0;
  logic [7:0] wr_data = 0;
  logic [7:0] rd_data, erase_sel;
  logic       multi_err;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [7:0] exp_q[$];
  logic       rd_pend = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  erase_sel_reg uut (
    .clk(clk), .rst_n(rst_n), .hw_stby(hw_stby), .sw_stby(sw_stby),
    .op_mode(op_mode), .fwe_pin(fwe_pin), .swe_bit(swe_bit),
    .wr_stb(wr_stb), .wr_data(wr_data), .rd_stb(rd_stb), .err_ack(err_ack),
    .rd_data(rd_data), .erase_sel(erase_sel), .multi_err(multi_err)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] d);
    wr_data = d; wr_stb = 1;
    step();
    wr_stb = 0;
  endtask

  task automatic rd(input logic [7:0] exp);
    exp_q.push_back(exp);
    rd_stb = 1;
    step();
    rd_stb = 0;
    step();
  endtask

  always @(posedge clk) rd_pend <= rd_stb;

  always @(negedge clk) begin
    if (rd_pend) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R9 unexpected read actual %h expected none", rd_data);
      end else begin
        chk("R9 read value", rd_data, exp_q.pop_front());
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual hung expected done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    step(); step();
    chk("R1 reset sel", erase_sel, 8'h00);
    chk("R1 reset err", {7'd0, multi_err}, 8'h00);
    chk("R1 reset rd", rd_data, 8'h00);
    rst_n = 1; step();
    rd(8'h00);
    // R6 single-bit and zero writes
    wr(8'h04); chk("R6 sel 04", erase_sel, 8'h04);
    rd(8'h04);
    chk("R9 idle rd zero", rd_data, 8'h00);
    wr(8'h80); chk("R6 sel 80", erase_sel, 8'h80);
    wr(8'h00); chk("R6 sel 00", erase_sel, 8'h00);
    // R7 multi-bit reject, sticky
    wr(8'h01); wr(8'h03);
    chk("R7 sel kept", erase_sel, 8'h01);
    chk("R7 err set", {7'd0, multi_err}, 8'h01);
    wr(8'h10);
    chk("R7 err sticky", {7'd0, multi_err}, 8'h01);
    chk("R6 write after err", erase_sel, 8'h10);
    // R8 ack with a rejected write in the same cycle keeps err
    err_ack = 1; wr(8'hC0); err_ack = 0;
    chk("R8 reject beats ack", {7'd0, multi_err}, 8'h01);
    err_ack = 1; step(); err_ack = 0;
    chk("R8 ack clears", {7'd0, multi_err}, 8'h00);
    chk("R8 ack keeps sel", erase_sel, 8'h10);
    // mode 7 writable
    op_mode = 3'd7; wr(8'h20); chk("R6 mode7 write", erase_sel, 8'h20);
    // R5 read-only modes
    op_mode = 3'd6; wr(8'h02); chk("R5 mode6 write ignored", erase_sel, 8'h20);
    rd(8'h00);
    op_mode = 3'd3; wr(8'h06);
    chk("R5 mode3 no err", {7'd0, multi_err}, 8'h00);
    chk("R5 mode3 write ignored", erase_sel, 8'h20);
    op_mode = 3'd5; rd(8'h20);
    // R10 combinational gating, R4 clear by swe
    swe_bit = 0; #1;
    chk("R10 same-cycle gate", erase_sel, 8'h00);
    step();
    wr(8'h01);
    swe_bit = 1; #1;
    chk("R4 cleared and write ignored", erase_sel, 8'h00);
    step(); rd(8'h00);
    // R3 clear by fwe
    wr(8'h08); chk("R6 sel 08", erase_sel, 8'h08);
    fwe_pin = 0; step(); wr(8'h02); fwe_pin = 1; #1;
    chk("R3 cleared and write ignored", erase_sel, 8'h00);
    step();
    // R2 hardware standby clears sel and err (R8)
    wr(8'h08); wr(8'hFF);
    chk("R7 err before stby", {7'd0, multi_err}, 8'h01);
    hw_stby = 1; step(); step(); hw_stby = 0;
    chk("R2 hw stby sel", erase_sel, 8'h00);
    chk("R8 hw stby err", {7'd0, multi_err}, 8'h00);
    rd(8'h00);
    // R2 software standby
    wr(8'h02); wr(8'h0A);
    sw_stby = 1; step(); sw_stby = 0;
    chk("R2 sw stby sel", erase_sel, 8'h00);
    chk("R8 sw stby err", {7'd0, multi_err}, 8'h00);
    // R11 clear wins over same-cycle write
    sw_stby = 1; wr(8'h40); sw_stby = 0;
    chk("R11 clear wins", erase_sel, 8'h00);
    rd(8'h00);
    // R1 reset mid-run
    wr(8'h02); rst_n = 0; #1;
    chk("R1 async reset", erase_sel, 8'h00);
    step(); rst_n = 1; step();
    rd(8'h00);
    step(); step();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule